// File: doc/BRIEF.md
# Serial Link Command Framer

This block is the transmit half of a two-wire master link made of a link clock and a data line. On a request it builds one addressed register-access command (read or write, to one of four slaves, 1, 2 or 4 bytes wide). It then sends the command on a link clock divided down from the system clock. The data line uses inverted coding: a logical 1 is a low line.

After the command it appends a 4-bit CRC and holds the line idle for a guard period. It then raises a one-cycle done pulse so that a response receiver can take the line. The same engine also produces two fixed line patterns: a long break that resets the far end, and a link-initialisation run of idle clocks.

Each link clock period has two phases. The low phase lasts `lo_cnt_i` system cycles and the high phase lasts `hi_cnt_i` system cycles. The far end samples data on the rising edge, and the data line only moves during the low phase.

Top module: `link_cmd_framer`

## Requirements
- R1: Out of reset, and whenever busy is low, the link clock and the data line are both high, and busy and done are low.
- R2: Each link period is `lo_cnt_i` system cycles low followed by `hi_cnt_i` cycles high (lo_cnt_i >= 2, hi_cnt_i >= 1). The data line never changes while the link clock is high.
- R3: `op_i` 0 requests a read and 1 requests a write. A command starts with one period of line low (a start bit, taken as logical 1). All later bits go MSB first and are inverted on the line, so the value seen at each rising edge is the complement of the logical bit.
- R4: The 28-bit header, first bit first, is: slave id (2 bits), a constant 1, two 0 bits, a read flag (1 for read), address bits 20..0, and one size bit. A zero `sid_i` is replaced by `addr_i[22:21]`.
- R5: The size code is ORed into the two last header positions (address bit 0 and the size bit). `size_i` 0 (1 byte) gives 00, 1 (2 bytes) gives 01, and 2 or 3 (4 bytes) gives 11.
- R6: A write sends the low 8, 16 or 32 bits of `wdata_i`, MSB first, right after the header. A read sends no data bits.
- R7: Four CRC bits end the command. They are the remainder of polynomial x^4+x^2+x+1, starting from 0, taken MSB first over the start bit, the header and the data.
- R8: Each command is followed by 16 periods of line high.
- R9: `op_i` 2 sends a break: 50 periods high, 256 periods low, then 16016 periods high.
- R10: `op_i` 3 sends link initialisation: 5000 periods with the line high.
- R11: Busy rises the cycle after a request is accepted. Done is a one-cycle pulse in the first cycle busy is low again.
- R12: A request raised while busy is ignored. The running sequence is unchanged and no new one starts after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start request, taken when idle |
| op_i | input | 2 | 0 read, 1 write, 2 break, 3 init |
| sid_i | input | 2 | Slave id, 0 selects address bits 22:21 |
| addr_i | input | 23 | Address, bits 22:21 used as fallback slave id |
| size_i | input | 2 | 0 one byte, 1 two bytes, 2/3 four bytes |
| wdata_i | input | 32 | Write data, low bits used for narrow sizes |
| lo_cnt_i | input | 8 | System cycles of link clock low phase |
| hi_cnt_i | input | 8 | System cycles of link clock high phase |
| lclk_o | output | 1 | Link clock |
| sda_o | output | 1 | Link data line level |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The properties on clock shape and data stability rely on the low-phase count being at least two and the high-phase count at least one. They also rely on both counts staying constant while busy is high. The stimulus writes the divider counts only in idle cycles before raising a request, and only uses settings of 2/1, 3/2 and 2/2. Requests raised during a sequence are a deliberate probe of the ignore rule, never a change of divider settings.

// File: rtl/link_framer_pkg.sv
package link_framer_pkg;
  typedef enum logic [1:0] {OP_RD = 2'd0, OP_WR = 2'd1, OP_BRK = 2'd2, OP_INIT = 2'd3} op_e;
  typedef enum logic [3:0] {
    ST_IDLE, ST_BODY, ST_CRC, ST_GUARD, ST_BPRE, ST_BLOW, ST_BGRD, ST_BPOST, ST_INIT
  } st_e;

  // x^4+x^2+x+1, MSB first
  function automatic logic [3:0] crc4_step(logic [3:0] c, logic b);
    logic fb;
    fb = c[3] ^ b;
    return {c[2:0], 1'b0} ^ (fb ? 4'b0111 : 4'b0000);
  endfunction
endpackage

// File: rtl/link_clk_div.sv
module link_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             last_i,
  input  logic [DIV_W-1:0] lo_i,
  input  logic [DIV_W-1:0] hi_i,
  output logic             lclk_o,
  output logic             fall_o,
  output logic             pend_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             run_q;
  logic             lclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      lclk_q <= 1'b1;
    end else if (!en_i) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      lclk_q <= 1'b1;
    end else if (!run_q) begin
      run_q  <= 1'b1;
      lclk_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!lclk_q) begin
      if (cnt_q == lo_i - 1'b1) begin
        lclk_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (cnt_q == hi_i - 1'b1) begin
      cnt_q <= '0;
      if (last_i) run_q  <= 1'b0;  // park high after final period
      else        lclk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lclk_o = lclk_q;
  assign fall_o = run_q & ~lclk_q & (cnt_q == '0);
  assign pend_o = run_q & lclk_q & (cnt_q == hi_i - 1'b1);
endmodule

// File: rtl/link_frame_build.sv
module link_frame_build #(
  parameter int ADDR_W = 21,
  parameter int SID_W  = 2,
  parameter int DATA_W = 32,
  parameter int BODY_W = 1 + SID_W + 5 + ADDR_W + DATA_W,
  parameter int LEN_W  = $clog2(BODY_W + 1)
) (
  input  logic                    rd_i,
  input  logic [SID_W-1:0]        sid_i,
  input  logic [ADDR_W+SID_W-1:0] addr_i,
  input  logic [1:0]              size_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [BODY_W-1:0]       body_o,
  output logic [LEN_W-1:0]        len_o
);
  localparam int HDR_W = SID_W + 5 + ADDR_W;

  logic [SID_W-1:0]  sid_eff;
  logic [1:0]        szc;
  int                dbits;
  logic [HDR_W-1:0]  hdr;
  logic [DATA_W-1:0] dal;

  always_comb begin
    sid_eff = (sid_i != '0) ? sid_i : addr_i[ADDR_W +: SID_W];
    case (size_i)
      2'd0:    begin szc = 2'b00; dbits = 8;  end
      2'd1:    begin szc = 2'b01; dbits = 16; end
      default: begin szc = 2'b11; dbits = 32; end
    endcase
    hdr      = {sid_eff, 1'b1, 2'b00, rd_i, addr_i[ADDR_W-1:0], 1'b0};
    hdr[1:0] = hdr[1:0] | szc;
    dal      = wdata_i << (DATA_W - dbits);
    if (rd_i) begin
      dal   = '0;
      dbits = 0;
    end
    body_o = {1'b1, hdr, dal};
    len_o  = LEN_W'(1 + HDR_W + dbits);
  end
endmodule

// File: rtl/link_cmd_framer.sv
module link_cmd_framer
  import link_framer_pkg::*;
#(
  parameter int ADDR_W        = 21,
  parameter int SID_W         = 2,
  parameter int DATA_W        = 32,
  parameter int DIV_W         = 8,
  parameter int GUARD_CLKS    = 16,
  parameter int BRK_PRE_CLKS  = 50,
  parameter int BRK_LOW_CLKS  = 256,
  parameter int BRK_POST_CLKS = 16000,
  parameter int INIT_CLKS     = 5000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic [1:0]              op_i,
  input  logic [SID_W-1:0]        sid_i,
  input  logic [ADDR_W+SID_W-1:0] addr_i,
  input  logic [1:0]              size_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic [DIV_W-1:0]        lo_cnt_i,
  input  logic [DIV_W-1:0]        hi_cnt_i,
  output logic                    lclk_o,
  output logic                    sda_o,
  output logic                    busy_o,
  output logic                    done_o
);
  localparam int BODY_W = 1 + SID_W + 5 + ADDR_W + DATA_W;
  localparam int LEN_W  = $clog2(BODY_W + 1);
  localparam int CNT_W  = $clog2(BRK_POST_CLKS + BRK_LOW_CLKS + BRK_PRE_CLKS
                                 + INIT_CLKS + GUARD_CLKS + BODY_W + 1);

  st_e               st_q, nxt;
  logic [CNT_W-1:0]  cnt_q, nxt_len;
  logic [BODY_W-1:0] sh_q, body;
  logic [LEN_W-1:0]  len;
  logic [3:0]        crc_q;
  logic              sda_q, done_q, level;
  logic              fall, pend, last_seg;

  link_frame_build #(
    .ADDR_W(ADDR_W), .SID_W(SID_W), .DATA_W(DATA_W), .BODY_W(BODY_W), .LEN_W(LEN_W)
  ) u_build (
    .rd_i   (op_i == OP_RD),
    .sid_i  (sid_i),
    .addr_i (addr_i),
    .size_i (size_i),
    .wdata_i(wdata_i),
    .body_o (body),
    .len_o  (len)
  );

  assign last_seg = (st_q inside {ST_GUARD, ST_BPOST, ST_INIT}) && (cnt_q == CNT_W'(1));

  link_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (st_q != ST_IDLE),
    .last_i(last_seg),
    .lo_i  (lo_cnt_i),
    .hi_i  (hi_cnt_i),
    .lclk_o(lclk_o),
    .fall_o(fall),
    .pend_o(pend)
  );

  always_comb begin
    case (st_q)
      ST_BODY:  nxt = ST_CRC;
      ST_CRC:   nxt = ST_GUARD;
      ST_BPRE:  nxt = ST_BLOW;
      ST_BLOW:  nxt = ST_BGRD;
      ST_BGRD:  nxt = ST_BPOST;
      default:  nxt = ST_IDLE;
    endcase
    case (nxt)
      ST_CRC:   nxt_len = CNT_W'(4);
      ST_GUARD: nxt_len = CNT_W'(GUARD_CLKS);
      ST_BLOW:  nxt_len = CNT_W'(BRK_LOW_CLKS);
      ST_BGRD:  nxt_len = CNT_W'(GUARD_CLKS);
      ST_BPOST: nxt_len = CNT_W'(BRK_POST_CLKS);
      default:  nxt_len = '0;
    endcase
    case (st_q)
      ST_BODY: level = ~sh_q[BODY_W-1];
      ST_CRC:  level = ~crc_q[3];
      ST_BLOW: level = 1'b0;
      default: level = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      crc_q  <= '0;
      sda_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (req_i) begin
          case (op_i)
            OP_BRK: begin
              st_q  <= ST_BPRE;
              cnt_q <= CNT_W'(BRK_PRE_CLKS);
            end
            OP_INIT: begin
              st_q  <= ST_INIT;
              cnt_q <= CNT_W'(INIT_CLKS);
            end
            default: begin
              st_q  <= ST_BODY;
              cnt_q <= CNT_W'(len);
              sh_q  <= body;
              crc_q <= '0;
            end
          endcase
        end
      end else begin
        if (fall) sda_q <= level;  // one cycle into the low phase
        if (pend) begin
          if (st_q == ST_BODY) begin
            crc_q <= crc4_step(crc_q, sh_q[BODY_W-1]);
            sh_q  <= sh_q << 1;
          end else if (st_q == ST_CRC) begin
            crc_q <= crc_q << 1;
          end
          if (cnt_q == CNT_W'(1)) begin
            st_q   <= nxt;
            cnt_q  <= nxt_len;
            done_q <= (nxt == ST_IDLE);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end
    end
  end

  assign sda_o  = sda_q;
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/link_framer_chk.sv
module link_framer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic lclk_o,
  input logic sda_o,
  input logic busy_o,
  input logic done_o
);
  AST_IDLE_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (lclk_o && sda_o)); // R1
  AST_SDA_STILL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lclk_o && $past(lclk_o)) |-> $stable(sda_o)); // R2
  AST_LOW_MIN_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lclk_o) |=> !lclk_o); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R11
endmodule

bind link_cmd_framer link_framer_chk u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .lclk_o(lclk_o),
  .sda_o (sda_o),
  .busy_o(busy_o),
  .done_o(done_o)
);

// File: tb/link_cmd_framer_test.sv
`timescale 1ns/1ps
module link_cmd_framer_test;
  localparam int CAP = 16400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  op = '0, sid = '0, sz = '0;
  logic [22:0] addr = '0;
  logic [31:0] wd = '0;
  logic [7:0]  lo_cnt = 8'd2, hi_cnt = 8'd1;
  logic        lclk, sda, busy, done;

  int total = 0, bad = 0;
  bit finished = 0;

  logic cap [CAP];
  logic expv [CAP];
  int   cap_n = 0, exp_n = 0, body_n = 0;
  int   cyc = 0, last_rise = 0, per_bad = 0, hi_chg = 0, cur_per = 3;
  bit   rise_valid = 0;
  logic prev_lclk = 1'b1, prev_sda = 1'b1;

  link_cmd_framer uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .sid_i(sid),
    .addr_i(addr), .size_i(sz), .wdata_i(wd), .lo_cnt_i(lo_cnt), .hi_cnt_i(hi_cnt),
    .lclk_o(lclk), .sda_o(sda), .busy_o(busy), .done_o(done)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (lclk && !prev_lclk) begin
        if (cap_n < CAP) cap[cap_n] = sda;
        cap_n++;
        if (rise_valid && (cyc - last_rise) != cur_per) per_bad++;
        rise_valid = 1;
        last_rise  = cyc;
      end
      if (lclk && prev_lclk && sda != prev_sda) hi_chg++;
      if (!busy) rise_valid = 0;
    end
    prev_lclk = lclk;
    prev_sda  = sda;
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int ex);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, ex);
    end
  endtask

  function automatic logic [3:0] st4(logic [3:0] c, logic b);
    return {c[2:0], 1'b0} ^ ((c[3] ^ b) ? 4'h7 : 4'h0);
  endfunction

  task automatic push(input logic v);
    if (exp_n < CAP) expv[exp_n] = v;
    exp_n++;
  endtask

  task automatic build_frame(input logic [1:0] o, input logic [1:0] s, input logic [22:0] a,
                             input logic [1:0] z, input logic [31:0] w);
    logic [1:0]  se, szc;
    logic [27:0] hdr;
    logic [3:0]  c;
    int d;
    se  = (s != 0) ? s : a[22:21];
    szc = (z == 0) ? 2'b00 : (z == 1) ? 2'b01 : 2'b11;
    d   = (o == 2'd1) ? ((z == 0) ? 8 : (z == 1) ? 16 : 32) : 0;
    hdr = {se, 1'b1, 2'b00, (o == 2'd0), a[20:0], 1'b0} | {26'd0, szc};
    exp_n = 0;
    c = 4'h0;
    push(1'b0);
    c = st4(c, 1'b1);
    for (int i = 27; i >= 0; i--) begin push(~hdr[i]); c = st4(c, hdr[i]); end
    for (int i = d - 1; i >= 0; i--) begin push(~w[i]); c = st4(c, w[i]); end
    body_n = exp_n;
    for (int i = 3; i >= 0; i--) push(~c[i]);
    for (int i = 0; i < 16; i++) push(1'b1);
  endtask

  function automatic int first_bad(input int a, input int b);
    for (int i = a; i < b; i++) if (cap[i] !== expv[i]) return i;
    return -1;
  endfunction

  task automatic run_op(input logic [1:0] o, input logic [1:0] s, input logic [22:0] a,
                        input logic [1:0] z, input logic [31:0] w, input int lo, input int hi,
                        input bit poke);
    int guard, dones;
    @(negedge clk);
    lo_cnt = 8'(lo); hi_cnt = 8'(hi); cur_per = lo + hi;
    cap_n = 0; per_bad = 0; hi_chg = 0;
    op = o; sid = s; addr = a; sz = z; wd = w; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk(busy === 1'b1, "R11", "busy after accept", int'(busy), 1);
    dones = 0; guard = 0;
    while (dones == 0 && guard < 80000) begin
      @(negedge clk);
      guard++;
      if (poke && (guard == 40 || guard == 41)) begin req = 1'b1; op = 2'd2; end
      else req = 1'b0;
      if (done) begin
        dones++;
        chk(busy === 1'b0, "R11", "busy low at done", int'(busy), 0);
      end
    end
    chk(dones == 1, "R11", "done pulse seen", dones, 1);
    chk(per_bad == 0, "R2", "period length errors", per_bad, 0);
    chk(hi_chg == 0, "R2", "data moved while clock high", hi_chg, 0);
  endtask

  task automatic check_frame(input string tag);
    int fb;
    logic [3:0] c;
    chk(cap_n == exp_n, "R3", {tag, " period count"}, cap_n, exp_n);
    fb = first_bad(0, body_n);
    chk(fb < 0, "R3/R4/R5/R6", {tag, " body first bad index"}, fb, -1);
    fb = first_bad(body_n, body_n + 4);
    chk(fb < 0, "R7", {tag, " crc first bad index"}, fb, -1);
    c = 4'h0;
    for (int i = 0; i < body_n + 4; i++) c = st4(c, ~cap[i]);
    chk(c == 4'h0, "R7", {tag, " crc residue"}, int'(c), 0);
    fb = first_bad(body_n + 4, exp_n);
    chk(fb < 0, "R8", {tag, " guard first bad index"}, fb, -1);
  endtask

  initial begin
    logic [22:0] alist [2];
    int k;
    alist[0] = 23'h600001;
    alist[1] = 23'h2ABCDE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lclk === 1'b1 && sda === 1'b1, "R1", "idle line after reset", int'({lclk, sda}), 3);
    chk(busy === 1'b0 && done === 1'b0, "R1", "idle flags after reset", int'({busy, done}), 0);

    // sweep op x slave id x size x address, varying divider
    k = 0;
    for (int o = 0; o < 2; o++)
      for (int s = 0; s < 4; s++)
        for (int z = 0; z < 4; z++)
          for (int ai = 0; ai < 2; ai++) begin
            logic [31:0] w;
            w = 32'hA5C3_1E69 ^ (32'h0101_0101 * k);
            build_frame(2'(o), 2'(s), alist[ai], 2'(z), w);
            case (k % 3)
              0: run_op(2'(o), 2'(s), alist[ai], 2'(z), w, 2, 1, 0);
              1: run_op(2'(o), 2'(s), alist[ai], 2'(z), w, 3, 2, 0);
              default: run_op(2'(o), 2'(s), alist[ai], 2'(z), w, 2, 2, 0);
            endcase
            check_frame(o == 0 ? "read" : "write");
            k++;
          end

    // R12: break request raised mid-write is ignored
    build_frame(2'd1, 2'd2, 23'h15A5A5, 2'd2, 32'h8000_0001);
    run_op(2'd1, 2'd2, 23'h15A5A5, 2'd2, 32'h8000_0001, 2, 2, 1);
    check_frame("R12 poked write");
    begin
      int act;
      act = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (busy || !lclk || !sda) act++;
      end
      chk(act == 0, "R12", "activity after ignored request", act, 0);
    end

    // R9: break
    exp_n = 0;
    for (int i = 0; i < 50; i++) push(1'b1);
    for (int i = 0; i < 256; i++) push(1'b0);
    for (int i = 0; i < 16016; i++) push(1'b1);
    run_op(2'd2, 2'd0, 23'd0, 2'd0, 32'd0, 2, 1, 0);
    chk(cap_n == 16322, "R9", "break period count", cap_n, 16322);
    chk(first_bad(0, 16322) < 0, "R9", "break first bad index", first_bad(0, 16322), -1);

    // R10: link initialisation
    exp_n = 0;
    for (int i = 0; i < 5000; i++) push(1'b1);
    run_op(2'd3, 2'd0, 23'd0, 2'd0, 32'd0, 2, 1, 0);
    chk(cap_n == 5000, "R10", "init period count", cap_n, 5000);
    chk(first_bad(0, 5000) < 0, "R10", "init first bad index", first_bad(0, 5000), -1);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(190000 * 5);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule